// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Down-Counter Pair

The block holds two 8-bit down-counters, a low half and a high half. A mode bit decides how they are used. With the bit clear they are two independent timers. With the bit set they form one 16-bit timer, and the low half sets the pace for the whole pair. Each half counts down from its reload value to zero. On the next count tick it wraps back to the reload value and raises a one-cycle underflow pulse.

Each half takes its count tick from one of two places. The first is a shared external event input, resynchronized into the system clock domain, in which case each rising edge counts as one event. The second is an internal prescaler. The prescaler divides one of two oscillator clock-enable streams, fast or slow, by a ratio chosen with a 3-bit code. All control lives in a small byte-wide register bank, and every field reads back as written.

In 16-bit mode the high half's configuration is ignored. The pair behaves as a single counter with the value {high, low}: the low half borrows into the high half when it passes zero, and a single underflow is reported on the high output.

Top module: `timer_pair`

## Requirements
- R1: Register 0 bit 0 is the mode bit and resets to 0. With 0, the halves count independently. With 1, the halves form one 16-bit counter. The bit reads back as written, and bits 7:1 read 0.
- R2: Registers 1 (low) and 2 (high) are half configuration bytes: bit 0 external select, bit 1 slow source, bits 4:2 divider code, bit 5 run, bits 7:6 read 0. Registers 3 and 4 are the low and high reload values. Registers 5 and 6 return the low and high live counts. Every register reads 0 after reset.
- R3: A running half decrements once per tick. A tick at zero reloads the half and produces a one-cycle pulse on its underflow output, so pulses repeat every (reload+1) ticks.
- R4: With external select set, a half counts rising edges of `ext_evt_i` after a two-stage synchronizer. Each edge lowers the count by exactly one.
- R5: With external select clear, the slow source bit picks `osc_slow_en_i` (1) or `osc_fast_en_i` (0) as the prescaler input.
- R6: Divider codes 0 to 7 give one tick per 1, 2, 4, 8, 16, 32, 64 and 256 pulses of the selected oscillator enable.
- R7: In 16-bit mode the whole high configuration byte has no effect. The low configuration drives the pair, and {high, low} counts down by one per low tick. `uf_hi_o` pulses once every ({reload_hi, reload_lo}+1) ticks, and `uf_lo_o` stays 0.
- R8: While a half is not running (in 16-bit mode, while the low run bit is clear), its count is held at its reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_fast_en_i | input | 1 | Fast oscillator clock-enable pulses |
| osc_slow_en_i | input | 1 | Slow oscillator clock-enable pulses |
| ext_evt_i | input | 1 | Asynchronous external event input |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data of the addressed register |
| uf_lo_o | output | 1 | Low half underflow pulse (split mode only) |
| uf_hi_o | output | 1 | High half underflow pulse, or 16-bit underflow |

## Verification
The bench builds the block with its default 8-bit count width, two synchronizer stages and an 8-bit prescaler. This lets a 16-bit wrap at {1, 3} complete in 260 cycles and the largest divider (256) complete in one period.

The fast enable is held high, so the internal ratios map directly to cycle counts. The slow enable pulses every fourth cycle, which separates the two sources by a factor of four.

Measuring the interval between underflow pulses makes the reload, divider and cascade arithmetic visible in a single number per configuration.

// File: rtl/timer_pair_pkg.sv
package timer_pair_pkg;

  typedef struct packed {
    logic       run;
    logic [2:0] div;
    logic       slow;
    logic       ext;
  } half_cfg_t;

  localparam int unsigned CFG_W = $bits(half_cfg_t);

  localparam logic [2:0] A_MODE   = 3'd0;
  localparam logic [2:0] A_CFG_LO = 3'd1;
  localparam logic [2:0] A_CFG_HI = 3'd2;
  localparam logic [2:0] A_REL_LO = 3'd3;
  localparam logic [2:0] A_REL_HI = 3'd4;
  localparam logic [2:0] A_CNT_LO = 3'd5;
  localparam logic [2:0] A_CNT_HI = 3'd6;

endpackage

// File: rtl/tp_edge_sync.sv
module tp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;
  logic            rise_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // edge taken between the last sync stage and one extra history bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rise_q <= 1'b0;
    else         rise_q <= pipe_q[STAGES-1] & ~pipe_q[STAGES];
  end

  assign rise_o = rise_q;

  // R4
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/tp_prescaler.sv
module tp_prescaler #(
  parameter int unsigned PRE_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       src_en_i,
  input  logic [2:0] div_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [3:0]       shift;
  logic [PRE_W-1:0] mask;
  logic             tick_q;

  // code 7 jumps to /256, the rest are 2**code
  always_comb begin
    shift = (div_i == 3'd7) ? 4'd8 : {1'b0, div_i};
    mask  = PRE_W'((32'd1 << shift) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= src_en_i & ((cnt_q & mask) == mask);
      if (src_en_i) cnt_q <= cnt_q + PRE_W'(1);
    end
  end

  assign tick_o = tick_q;

  // R6
  tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ($past(src_en_i) && !$past(clr_i)));

endmodule

// File: rtl/tp_down_counter.sv
module tp_down_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= reload_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign count_o = cnt_q;
  assign zero_o  = (cnt_q == '0);

  // R8
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_o == $past(reload_i)));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(count_o));

endmodule

// File: rtl/timer_pair.sv
module timer_pair
  import timer_pair_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PRE_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_fast_en_i,
  input  logic             osc_slow_en_i,
  input  logic             ext_evt_i,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             uf_lo_o,
  output logic             uf_hi_o
);
  localparam int unsigned HALVES = 2;

  logic             fuse_q;
  half_cfg_t        cfg_q [HALVES];
  logic [CNT_W-1:0] rel_q [HALVES];
  logic [CNT_W-1:0] cnt   [HALVES];
  logic [HALVES-1:0] pre_tick, tick, run_eff, ld, dec, zero;
  logic             ext_rise;
  logic             both_zero;
  logic             uf_lo_q, uf_hi_q;

  // register bank
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fuse_q <= 1'b0;
      for (int h = 0; h < HALVES; h++) begin
        cfg_q[h] <= '0;
        rel_q[h] <= '0;
      end
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_MODE:   fuse_q   <= wdata_i[0];
        A_CFG_LO: cfg_q[0] <= half_cfg_t'(wdata_i[CFG_W-1:0]);
        A_CFG_HI: cfg_q[1] <= half_cfg_t'(wdata_i[CFG_W-1:0]);
        A_REL_LO: rel_q[0] <= wdata_i;
        A_REL_HI: rel_q[1] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      A_MODE:   rdata_o = CNT_W'(fuse_q);
      A_CFG_LO: rdata_o = CNT_W'(cfg_q[0]);
      A_CFG_HI: rdata_o = CNT_W'(cfg_q[1]);
      A_REL_LO: rdata_o = rel_q[0];
      A_REL_HI: rdata_o = rel_q[1];
      A_CNT_LO: rdata_o = cnt[0];
      A_CNT_HI: rdata_o = cnt[1];
      default:  rdata_o = '0;
    endcase
  end

  tp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (ext_evt_i),
    .rise_o  (ext_rise)
  );

  // high half only runs on its own in split mode
  assign run_eff[0] = cfg_q[0].run;
  assign run_eff[1] = cfg_q[1].run & ~fuse_q;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    tp_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (~run_eff[h]),
      .src_en_i (cfg_q[h].slow ? osc_slow_en_i : osc_fast_en_i),
      .div_i    (cfg_q[h].div),
      .tick_o   (pre_tick[h])
    );

    assign tick[h] = cfg_q[h].ext ? ext_rise : pre_tick[h];

    tp_down_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (ld[h]),
      .dec_i    (dec[h]),
      .reload_i (rel_q[h]),
      .count_o  (cnt[h]),
      .zero_o   (zero[h])
    );
  end

  assign both_zero = zero[0] & zero[1];

  always_comb begin
    if (!fuse_q) begin
      for (int h = 0; h < HALVES; h++) begin
        ld[h]  = ~run_eff[h] | (tick[h] & zero[h]);
        dec[h] = run_eff[h] & tick[h];
      end
    end else begin
      // low borrows into high; both reload only at 16-bit zero
      ld[0]  = ~run_eff[0] | (tick[0] & both_zero);
      ld[1]  = ld[0];
      dec[0] = run_eff[0] & tick[0];
      dec[1] = run_eff[0] & tick[0] & zero[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_lo_q <= 1'b0;
      uf_hi_q <= 1'b0;
    end else begin
      uf_lo_q <= ~fuse_q & run_eff[0] & tick[0] & zero[0];
      uf_hi_q <= fuse_q ? (run_eff[0] & tick[0] & both_zero)
                        : (run_eff[1] & tick[1] & zero[1]);
    end
  end

  assign uf_lo_o = uf_lo_q;
  assign uf_hi_o = uf_hi_q;

  // R7
  fused_lo_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_q && $past(fuse_q)) |-> !uf_lo_o);

  // R7
  hi_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fuse_q && $past(fuse_q) && cfg_q[0].run && $past(cfg_q[0].run)
     && (cnt[1] != $past(cnt[1]))) |-> $past(zero[0]));

  // R3
  uf_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_lo_o && !$past(fuse_q)) |-> $past(zero[0]));

endmodule

// File: tb/timer_pair_test.sv
module timer_pair_test;
  import timer_pair_pkg::*;

  localparam int KREAD = 0, KPER_LO = 1, KPER_HI = 2, KQUIET_LO = 3;

  typedef struct {
    int    kind;
    int    exp;
    string tag;
  } item_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       osc_fast_en_i = 1'b1;
  logic       osc_slow_en_i = 1'b0;
  logic       ext_evt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       uf_lo_o, uf_hi_o;

  int    errors = 0;
  int    checks = 0;
  item_t q[$];
  logic  busy = 1'b0;
  logic  done = 1'b0;

  timer_pair uut (
    .clk_i, .rst_ni, .osc_fast_en_i, .osc_slow_en_i, .ext_evt_i,
    .wr_en_i, .addr_i, .wdata_i, .rdata_o, .uf_lo_o, .uf_hi_o
  );

  always #5 clk_i = ~clk_i;

  // slow oscillator enable: one pulse every fourth cycle
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk_i);
      ph = (ph + 1) % 4;
      osc_slow_en_i = (ph == 0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic push(input int kind, input int exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    #1;
    wait (q.size() == 0 && !busy);
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk_i);
    addr_i = a;
    push(KREAD, exp, tag);
  endtask

  task automatic ext_pulse();
    @(negedge clk_i); ext_evt_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ext_evt_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  function automatic void score(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // monitor: pops expectations and compares what the design produces
  initial begin
    forever begin
      item_t it;
      int    n;
      wait (q.size() > 0);
      it = q.pop_front();
      busy = 1'b1;
      case (it.kind)
        KREAD: score(it.tag, int'(rdata_o), it.exp);
        KPER_LO, KPER_HI: begin
          do @(negedge clk_i); while (!(it.kind == KPER_LO ? uf_lo_o : uf_hi_o));
          n = 0;
          do begin
            @(negedge clk_i);
            n++;
          end while (!(it.kind == KPER_LO ? uf_lo_o : uf_hi_o));
          score(it.tag, n, it.exp);
        end
        default: begin
          n = 0;
          repeat (600) begin
            @(negedge clk_i);
            if (uf_lo_o) n++;
          end
          score(it.tag, n, it.exp);
        end
      endcase
      busy = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 R2: reset state
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 0, "R2 reset value");
    rd_chk(A_MODE, 0, "R1 mode reset");

    // R1 R2: readback
    wr(A_MODE, 8'hFF);     rd_chk(A_MODE, 1, "R1 mode readback");
    wr(A_MODE, 8'h00);     rd_chk(A_MODE, 0, "R1 mode clear");
    wr(A_CFG_HI, 8'hFF);   rd_chk(A_CFG_HI, 8'h3F, "R2 cfg readback");
    wr(A_CFG_HI, 8'h00);
    wr(A_REL_HI, 8'hA5);   rd_chk(A_REL_HI, 8'hA5, "R2 reload readback");

    // R8: stopped half holds reload
    wr(A_REL_LO, 8'h5A);   rd_chk(A_CNT_LO, 8'h5A, "R8 held at reload");
    rd_chk(A_CNT_HI, 8'hA5, "R8 high held at reload");

    // R4: external edges
    wr(A_REL_LO, 8'd10);
    wr(A_CFG_LO, 8'h21);
    repeat (3) ext_pulse();
    repeat (4) @(negedge clk_i);
    rd_chk(A_CNT_LO, 7, "R4 external edge count");
    wr(A_CFG_LO, 8'h00);

    // R3 R6: split halves run independently
    wr(A_REL_LO, 8'd4);
    wr(A_REL_HI, 8'd9);
    wr(A_CFG_LO, 8'h2C);   // run, /8
    wr(A_CFG_HI, 8'h24);   // run, /2
    push(KPER_LO, 40, "R3 R6 low period /8");
    push(KPER_HI, 20, "R3 R6 high period /2");
    wr(A_CFG_LO, 8'h00);
    wr(A_CFG_HI, 8'h00);

    // R5: slow source
    wr(A_REL_LO, 8'd2);
    wr(A_CFG_LO, 8'h26);   // run, slow, /2
    push(KPER_LO, 24, "R5 slow source period");
    wr(A_CFG_LO, 8'h00);

    // R6: /32 and /256
    wr(A_REL_LO, 8'd1);
    wr(A_CFG_LO, 8'h34);
    push(KPER_LO, 64, "R6 divider code 5");
    wr(A_CFG_LO, 8'h00);
    wr(A_REL_LO, 8'd0);
    wr(A_CFG_LO, 8'h3C);
    push(KPER_LO, 256, "R6 divider code 7");
    wr(A_CFG_LO, 8'h00);

    // R3: reload 0 at /1 wraps every cycle
    wr(A_CFG_LO, 8'h20);
    push(KPER_LO, 1, "R3 reload zero period");
    wr(A_CFG_LO, 8'h00);

    // R7: fused, high config all set but ignored
    wr(A_MODE, 8'h01);
    wr(A_REL_LO, 8'd3);
    wr(A_REL_HI, 8'd1);
    wr(A_CFG_HI, 8'h3F);
    wr(A_CFG_LO, 8'h20);
    push(KPER_HI, 260, "R7 16-bit period");
    push(KQUIET_LO, 0, "R7 low pulses in 16-bit mode");
    rd_chk(A_CFG_HI, 8'h3F, "R2 high cfg kept in 16-bit mode");
    wr(A_CFG_LO, 8'h00);
    rd_chk(A_CNT_HI, 1, "R8 fused stop reloads high");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule